// File: doc/BRIEF.md
# External-Clock Serial ADC Reader

This block is the host side of a link to a 16-bit sampling converter whose serial port is clocked by the host. A one-cycle start request makes the block pulse the converter's read/convert line low with chip-select low. It then parks the link with chip-select high, read/convert low and the serial clock low until the converter's busy flag rises. After that it selects the output mode (chip-select low, read/convert high), waits out a setup interval and generates its own serial clock. It shifts in one word, most significant bit first, and presents it on a parallel bus with a one-cycle valid strobe.

The read begins only after busy has risen, so the window in which the converter moves a new result into its output register never overlaps a clock pulse. Convert width, setup time and clock high and low phases are counts of system clock cycles. The top module checks them at elaboration against the converter's minimum timing: 40 ns convert pulse, 25 ns setup, 50 ns high, 40 ns low, 100 ns period, and a high time between 20 % and 70 % of the period.

Top module: `serial_adc_reader`

## Requirements
- R1: Out of reset and while no request is pending, `sel_n_o` and `read_o` are high and `sclk_o` and `valid_o` are low, and the serial clock does not pulse.
- R2: A `start_i` seen in the idle state makes `sel_n_o` and `read_o` both low together for exactly `CONV_CYC` cycles, starting on the next cycle.
- R3: From the end of the convert pulse until busy has risen, `sel_n_o` is high, `read_o` is low and `sclk_o` is low.
- R4: Output mode (`sel_n_o` low, `read_o` high) is entered only while `busy_i` is high, between 1 and `SYNC_STAGES`+2 cycles after busy rises. It is held with `sclk_o` low for exactly `SETUP_CYC`+1 cycles before the first clock rise.
- R5: Each read makes exactly `DATA_W` clock pulses. Each is high for `SCLK_HI_CYC` cycles, and consecutive pulses are separated by `SCLK_LO_CYC` low cycles.
- R6: `sclk_o` is high only while `sel_n_o` is low and `read_o` is high.
- R7: `sdin_i` is sampled in the last high cycle of each clock pulse. The bit of the first pulse becomes `result_o` bit `DATA_W`-1 and the bit of the last pulse becomes bit 0.
- R8: After the last pulse's falling edge the clock stays low for `SCLK_LO_CYC` cycles. Then `valid_o` is high for exactly one cycle, with `sel_n_o` and `read_o` back high, and `result_o` holds its value until the next strobe.
- R9: `start_i` has no effect while a transaction is in progress: no second convert pulse is issued, and the block returns to idle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request for a conversion and read |
| busy_i | input | 1 | Converter busy flag, asynchronous; low while converting |
| sdin_i | input | 1 | Serial data from the converter |
| sel_n_o | output | 1 | Chip-select to the converter, active low |
| read_o | output | 1 | High selects read/output mode, low starts a conversion |
| sclk_o | output | 1 | Generated serial data clock |
| result_o | output | DATA_W | Last word read |
| valid_o | output | 1 | One-cycle strobe marking a new `result_o` |

## Verification
The converter model in the bench is fed all-zero and all-one words, a lone MSB and a lone LSB, the two alternating patterns, a walking one through every bit position and a few scrambled words. The single-bit and walking patterns expose a reversed, rotated or off-by-one shift. The alternating words expose sampling on the wrong clock phase. Conversion lengths vary from word to word, so the busy wait is exercised with different timing. Every third transaction also pulses the start request during the busy wait and during shifting, which separates a sequencer that ignores it from one that restarts.

// File: rtl/adc_rd_pkg.sv
// Shared types of the serial ADC reader.
package adc_rd_pkg;
    // Sequencer states; the order carries no meaning.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_SETUP,
        ST_SHIFT,
        ST_DONE
    } rd_state_t;
endpackage

// File: rtl/adc_rd_sync.sv
// Synchroniser with rise detect for the converter busy flag.
// Assumes the flag idles high, so the chain resets to one and reset
// release never yields a false rise.
module adc_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    if (STAGES == 1) begin : g_single
        // Single flop variant.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= d_i;
        end
    end else begin : g_chain
        // Shift the asynchronous flag through the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    // Delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] && !last_q;
endmodule

// File: rtl/adc_rd_clkgen.sv
// Serial clock generator. While run_i is high it emits PULSES pulses,
// each HI_CYC cycles high and followed by LO_CYC cycles low. sample_o
// marks the last high cycle of a pulse; done_o marks the last low cycle
// after the final pulse. Dropping run_i returns it to rest at once.
module adc_rd_clkgen #(
    parameter int HI_CYC = 11,
    parameter int LO_CYC = 9,
    parameter int PULSES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic sample_o,
    output logic done_o
);
    localparam int PH_MAX = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int PC_W   = $clog2(PULSES + 1);

    logic [PH_W-1:0] phase_q;
    logic [PC_W-1:0] pulses_q;
    logic            phase_end;
    logic            all_sent;

    assign phase_end = (phase_q == '0);
    assign all_sent  = (pulses_q == PC_W'(PULSES));

    // Phase counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            sclk_o   <= 1'b0;
            phase_q  <= '0;
            pulses_q <= '0;
        end else if (sclk_o) begin
            if (phase_end) begin
                sclk_o   <= 1'b0;
                phase_q  <= PH_W'(LO_CYC - 1);
                pulses_q <= pulses_q + 1'b1;
            end else begin
                phase_q <= phase_q - 1'b1;
            end
        end else if (!phase_end) begin
            phase_q <= phase_q - 1'b1;
        end else if (!all_sent) begin
            sclk_o  <= 1'b1;
            phase_q <= PH_W'(HI_CYC - 1);
        end
    end

    assign sample_o = run_i && sclk_o && phase_end;
    assign done_o   = run_i && !sclk_o && phase_end && all_sent;
endmodule

// File: rtl/adc_rd_shreg.sv
// Serial-in shift register, first bit ends at the top. Cleared by clr_i.
module adc_rd_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    // Accumulate bits towards the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) word_o <= '0;
        else if (shift_i)    word_o <= {word_o[W-2:0], bit_i};
    end
endmodule

// File: rtl/serial_adc_reader.sv
// Host-side controller for a serial converter clocked by the host.
// Sequence: convert pulse, park until busy rises, select output mode,
// setup wait, DATA_W clock pulses, one-cycle result strobe.
// Assumes busy_i is asynchronous and idles high, and that a conversion
// lasts longer than the convert pulse plus the synchroniser delay.
module serial_adc_reader #(
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 5,
    parameter int CONV_CYC      = 10,
    parameter int SETUP_CYC     = 6,
    parameter int SCLK_HI_CYC   = 11,
    parameter int SCLK_LO_CYC   = 9,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_i,
    input  logic              sdin_i,
    output logic              sel_n_o,
    output logic              read_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);
    import adc_rd_pkg::*;

    localparam int MIN_CONV_NS   = 40;
    localparam int MIN_SETUP_NS  = 25;
    localparam int MIN_HI_NS     = 50;
    localparam int MIN_LO_NS     = 40;
    localparam int MIN_PERIOD_NS = 100;
    localparam int PERIOD_CYC    = SCLK_HI_CYC + SCLK_LO_CYC;
    localparam int CNT_MAX       = (CONV_CYC > SETUP_CYC) ? CONV_CYC : SETUP_CYC;
    localparam int CNT_W         = $clog2(CNT_MAX + 1);

    // Elaboration-time timing checks.
    if (CONV_CYC * CLK_PERIOD_NS < MIN_CONV_NS) begin : g_bad_conv
        $error("convert pulse shorter than converter minimum");
    end
    if ((SETUP_CYC + 1) * CLK_PERIOD_NS < MIN_SETUP_NS) begin : g_bad_setup
        $error("setup before first clock edge too short");
    end
    if (SCLK_HI_CYC * CLK_PERIOD_NS < MIN_HI_NS) begin : g_bad_hi
        $error("serial clock high phase too short");
    end
    if (SCLK_LO_CYC * CLK_PERIOD_NS < MIN_LO_NS) begin : g_bad_lo
        $error("serial clock low phase too short");
    end
    if (PERIOD_CYC * CLK_PERIOD_NS < MIN_PERIOD_NS) begin : g_bad_period
        $error("serial clock period too short");
    end
    if (SCLK_HI_CYC * 10 < PERIOD_CYC * 2 || SCLK_HI_CYC * 10 > PERIOD_CYC * 7) begin : g_bad_duty
        $error("serial clock duty cycle outside 20 to 70 percent");
    end

    rd_state_t          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               busy_rise;
    logic               sample;
    logic               shift_done;
    logic [DATA_W-1:0]  word;

    adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (busy_i),
        .rise_o (busy_rise)
    );

    adc_rd_clkgen #(
        .HI_CYC (SCLK_HI_CYC),
        .LO_CYC (SCLK_LO_CYC),
        .PULSES (DATA_W)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state_q == ST_SHIFT),
        .sclk_o   (sclk_o),
        .sample_o (sample),
        .done_o   (shift_done)
    );

    adc_rd_shreg #(.W(DATA_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (state_q == ST_SETUP),
        .shift_i (sample),
        .bit_i   (sdin_i),
        .word_o  (word)
    );

    // Transaction sequencer with its interval counter and result hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            result_o <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_CONV;
                    cnt_q   <= CNT_W'(CONV_CYC - 1);
                end
                ST_CONV: if (cnt_q == '0) state_q <= ST_WAIT;
                         else             cnt_q   <= cnt_q - 1'b1;
                ST_WAIT: if (busy_rise) begin
                    state_q <= ST_SETUP;
                    cnt_q   <= CNT_W'(SETUP_CYC - 1);
                end
                ST_SETUP: if (cnt_q == '0) state_q <= ST_SHIFT;
                          else             cnt_q   <= cnt_q - 1'b1;
                ST_SHIFT: if (shift_done) begin
                    state_q  <= ST_DONE;
                    result_o <= word;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Link levels decoded from the state register.
    always_comb begin
        sel_n_o = !(state_q == ST_CONV || state_q == ST_SETUP || state_q == ST_SHIFT);
        read_o  = !(state_q == ST_CONV || state_q == ST_WAIT);
        valid_o = (state_q == ST_DONE);
    end
endmodule

// File: rtl/adc_rd_checker.sv
// Protocol checker for serial_adc_reader; counters measure the phase
// widths so no window depends on a deep $past.
module adc_rd_checker #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYC    = 10,
    parameter int SETUP_CYC   = 6,
    parameter int SCLK_HI_CYC = 11,
    parameter int SCLK_LO_CYC = 9
) (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic sel_n_o,
    input logic read_o,
    input logic sclk_o,
    input logic valid_o
);
    logic        conv_now;
    logic        read_now;
    logic        sclk_d;
    logic [15:0] hi_run;
    logic [15:0] lo_run;
    logic [15:0] conv_run;
    logic [15:0] pulse_cnt;

    assign conv_now = !sel_n_o && !read_o;
    assign read_now = !sel_n_o && read_o;

    // Run-length and pulse counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            hi_run    <= '0;
            lo_run    <= '0;
            conv_run  <= '0;
            pulse_cnt <= '0;
        end else begin
            sclk_d    <= sclk_o;
            hi_run    <= sclk_o ? hi_run + 16'd1 : 16'd0;
            lo_run    <= (read_now && !sclk_o) ? lo_run + 16'd1 : 16'd0;
            conv_run  <= conv_now ? conv_run + 16'd1 : 16'd0;
            pulse_cnt <= read_now ? pulse_cnt + {15'd0, sclk_o && !sclk_d} : 16'd0;
        end
    end

    p_conv_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_now) |-> (conv_run == 16'(CONV_CYC)));

    p_quiet_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (!read_o && !sclk_o));

    p_read_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        read_now |-> busy_i);

    p_setup_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && pulse_cnt == 16'd0) |-> (lo_run == 16'(SETUP_CYC + 1)));

    p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_run == 16'(SCLK_HI_CYC)));

    p_low_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && pulse_cnt != 16'd0) |-> (lo_run == 16'(SCLK_LO_CYC)));

    p_pulse_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (pulse_cnt == 16'(DATA_W)));

    p_clock_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> read_now);

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_strobe_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sel_n_o && read_o));
endmodule

bind serial_adc_reader adc_rd_checker #(
    .DATA_W      (DATA_W),
    .CONV_CYC    (CONV_CYC),
    .SETUP_CYC   (SETUP_CYC),
    .SCLK_HI_CYC (SCLK_HI_CYC),
    .SCLK_LO_CYC (SCLK_LO_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (busy_i),
    .sel_n_o (sel_n_o),
    .read_o  (read_o),
    .sclk_o  (sclk_o),
    .valid_o (valid_o)
);

// File: tb/sim_serial_adc_reader.sv
// Bench: converter model plus per-transaction measurements.
module sim_serial_adc_reader;
    localparam int W     = 16;
    localparam int HI    = 11;
    localparam int LO    = 9;
    localparam int CONV  = 10;
    localparam int SETUP = 6;
    localparam int SYNC  = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         busy = 1'b1;
    logic         sdata = 1'b0;
    logic         sel_n;
    logic         rdsel;
    logic         sclk;
    logic [W-1:0] result;
    logic         valid;

    always #2.5 clk = ~clk;

    serial_adc_reader #(
        .DATA_W(W), .CLK_PERIOD_NS(5), .CONV_CYC(CONV), .SETUP_CYC(SETUP),
        .SCLK_HI_CYC(HI), .SCLK_LO_CYC(LO), .SYNC_STAGES(SYNC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy), .sdin_i(sdata),
        .sel_n_o(sel_n), .read_o(rdsel), .sclk_o(sclk), .result_o(result), .valid_o(valid)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Stimulus-side settings (written only by tasks)
    logic [W-1:0] pend_word = '0;
    int           conv_len_cfg = 20;
    bit           clr_req = 1'b0;

    // Model and monitor state (written only by the negedge block)
    logic [W-1:0] out_word, cap;
    int bit_idx, busy_cnt, since_busy;
    int n_conv_starts, conv_run, conv_w_last, hi_run, lo_run, n_pulses;
    int bad_hi, bad_lo, setup_w, n_valid, tail_lo, bad_valid_bus, r3_viol, r6_viol, read_lat;
    bit prev_conv, prev_sclk, prev_read;

    // Converter model and link monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        bit conv_now, read_now;
        conv_now = !sel_n && !rdsel;
        read_now = !sel_n && rdsel;
        if (!rst_n) begin
            busy = 1'b1; sdata = 1'b0; out_word = '0; cap = '0; bit_idx = W - 1;
            busy_cnt = 0; since_busy = 0;
            n_conv_starts = 0; conv_run = 0; conv_w_last = 0; hi_run = 0; lo_run = 0;
            n_pulses = 0; bad_hi = 0; bad_lo = 0; setup_w = 0; n_valid = 0; tail_lo = 0;
            bad_valid_bus = 0; r3_viol = 0; r6_viol = 0; read_lat = -1;
        end else begin
            if (clr_req) begin
                n_conv_starts = 0; conv_w_last = 0; n_pulses = 0; bad_hi = 0; bad_lo = 0;
                setup_w = 0; n_valid = 0; tail_lo = 0; bad_valid_bus = 0;
                r3_viol = 0; r6_viol = 0; read_lat = -1;
            end
            if (valid) begin
                n_valid++;
                cap = result;
                tail_lo = lo_run;
                if (!(sel_n && rdsel)) bad_valid_bus++;
            end
            if (!busy && !conv_now && !(sel_n && !rdsel && !sclk)) r3_viol++;
            if (sclk && !read_now) r6_viol++;
            if (conv_now) begin
                if (!prev_conv) begin
                    n_conv_starts++;
                    busy = 1'b0;
                    busy_cnt = conv_len_cfg;
                end
                conv_run++;
            end else if (prev_conv) begin
                conv_w_last = conv_run;
                conv_run = 0;
            end
            if (sclk) begin
                if (!prev_sclk) begin
                    if (n_pulses == 0) setup_w = lo_run;
                    else if (lo_run != LO) bad_lo++;
                    n_pulses++;
                    sdata = out_word[bit_idx];
                    if (bit_idx > 0) bit_idx--;
                    hi_run = 0;
                end
                hi_run++;
            end else begin
                if (prev_sclk && hi_run != HI) bad_hi++;
                if (read_now) begin
                    if (prev_sclk) lo_run = 0;
                    lo_run++;
                end else begin
                    lo_run = 0;
                end
            end
            if (read_now && !prev_read) read_lat = since_busy;
            if (busy) since_busy++;
            if (!busy && !(conv_now && !prev_conv)) begin
                if (busy_cnt == 0) begin
                    busy = 1'b1;
                    out_word = pend_word;
                    bit_idx = W - 1;
                    since_busy = 0;
                end else begin
                    busy_cnt--;
                end
            end
        end
        prev_conv = conv_now;
        prev_sclk = sclk;
        prev_read = read_now;
    end

    // Watchdog: a hung run counts as a failed check.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [W-1:0] pick(input int i);
        case (i)
            0: pick = 16'h0000;
            1: pick = 16'hFFFF;
            2: pick = 16'h8000;
            3: pick = 16'h0001;
            4: pick = 16'hAAAA;
            5: pick = 16'h5555;
            default: pick = (i < 22) ? (16'h0001 << (i - 6)) : (16'(i * 40503) ^ 16'h3C5A);
        endcase
    endfunction

    task automatic run_txn(input logic [W-1:0] word, input int clen, input bit poke,
                           input bit chk_hold, input logic [W-1:0] prev);
        @(posedge clk);
        pend_word = word;
        conv_len_cfg = clen;
        clr_req = 1'b1;
        @(negedge clk);
        #1 clr_req = 1'b0;
        if (chk_hold) chk(result == prev, "R8 hold", result, prev);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (14) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            for (int t = 0; t < 20000 && n_pulses < 5; t++) @(posedge clk);
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int t = 0; t < 20000 && n_valid == 0; t++) @(posedge clk);
        repeat (30) @(negedge clk);
        chk(conv_w_last == CONV, "R2 convert width", conv_w_last, CONV);
        chk(r3_viol == 0, "R3 parked levels", r3_viol, 0);
        chk(setup_w == SETUP + 1, "R4 setup cycles", setup_w, SETUP + 1);
        chk(read_lat >= 1 && read_lat <= SYNC + 2, "R4 busy to read", read_lat, SYNC + 1);
        chk(n_pulses == W, "R5 pulse count", n_pulses, W);
        chk(bad_hi == 0 && bad_lo == 0, "R5 phase widths", bad_hi + bad_lo, 0);
        chk(r6_viol == 0, "R6 clock in read mode", r6_viol, 0);
        chk(cap == word, "R7 result word", cap, word);
        chk(n_valid == 1, "R8 strobe length", n_valid, 1);
        chk(tail_lo == LO, "R8 trailing low", tail_lo, LO);
        chk(bad_valid_bus == 0, "R8 released at strobe", bad_valid_bus, 0);
        chk(n_conv_starts == 1, poke ? "R9 single conversion" : "R2 single conversion",
            n_conv_starts, 1);
        if (poke) chk(sel_n && rdsel && !sclk, "R9 back to idle", {sel_n, rdsel, sclk}, 3'b110);
    endtask

    initial begin
        logic [W-1:0] last;
        last = '0;
        repeat (5) @(negedge clk);
        chk(sel_n && rdsel && !sclk && !valid, "R1 reset levels", {sel_n, rdsel, sclk, valid}, 4'b1100);
        @(negedge clk) rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(sel_n && rdsel && !sclk && !valid, "R1 idle levels", {sel_n, rdsel, sclk, valid}, 4'b1100);
        chk(n_pulses == 0 && n_conv_starts == 0, "R1 no activity", n_pulses + n_conv_starts, 0);
        for (int i = 0; i < 25; i++) begin
            logic [W-1:0] w;
            w = pick(i);
            run_txn(w, 20 + (i % 5) * 11, (i % 3) == 2, i > 0, last);
            last = w;
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule